// File: doc/BRIEF.md
# Signed Integer Remainder Unit

This block computes the signed remainder of a two's-complement dividend divided by a two's-complement divisor, with the quotient truncated toward zero. It is a multi-cycle sequential unit. A start pulse hands it both operands. It divides their magnitudes one quotient bit per cycle with a restoring shift-subtract loop, corrects the signs, and then raises a one-cycle done pulse. The remainder and the truncated quotient stay on the outputs until the next accepted start.

Two corner cases have fixed results and never trap. A zero divisor gives the dividend back as the remainder. The most negative dividend divided by minus one gives a zero remainder. The unit spots both cases in the cycle after the operands are latched and skips the loop. Optionally, the unit can check a 32-bit instruction word at launch and accept the start only if the word encodes the register-register signed remainder operation.

The controller is a five-state machine:

- `ST_IDLE` waits for an accepted start.
- `ST_SETUP` classifies the latched operands.
- `ST_ITER` runs WIDTH shift-subtract steps.
- `ST_FIXUP` applies the signs.
- `ST_DONE` presents done.

The transitions are:

- IDLE to SETUP on an accepted start.
- SETUP to DONE when the case is special.
- SETUP to ITER otherwise.
- ITER to itself until the last step, then to FIXUP.
- FIXUP to DONE.
- DONE to IDLE unconditionally.

A synchronous reset forces IDLE from any state.

Top module: `srem_unit`

## Requirements
- R1: For a nonzero divisor, other than the overflow pair, the remainder equals dividend minus divisor times the zero-truncated quotient. A nonzero remainder carries the sign bit of the dividend, whatever the divisor's sign.
- R2: When the divisor is zero, the remainder equals the dividend unchanged, the quotient is all ones, and the operation completes like any other with no extra indication.
- R3: When the dividend is the most negative value and the divisor is minus one, the remainder is zero and the quotient is the most negative value.
- R4: Count the rising edge that samples an accepted start as edge 1. In the zero-divisor and overflow cases, done is high after edge 2. In all other cases, done is high after edge WIDTH+3.
- R5: done is high for exactly one cycle per accepted start. busy is high from the edge after acceptance through the done cycle, and low otherwise.
- R6: A start pulse while busy is high is ignored. The operands presented with it do not affect the result of the running operation.
- R7: remainder and quotient do not change from the done cycle until the next accepted start, whatever happens on the operand inputs.
- R8: With check_instr high, a start is accepted only if instr has [6:0]=0110011, [14:12]=110 and [31:25]=0000001. Bits [24:15] and [11:7] (the register fields) do not matter. Any other word leaves the unit idle with busy low and the outputs unchanged. With check_instr low, instr is ignored.
- R9: An active-high synchronous reset, applied in any state, returns the unit to idle with busy and done low after the next edge.
- R10: In the general case, quotient is the dividend divided by the divisor, truncated toward zero, and divisor × quotient + remainder equals the dividend modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, sampled while idle |
| check_instr | input | 1 | When high, start requires a matching instruction word |
| instr | input | 32 | Instruction word checked against the signed remainder encoding |
| dividend | input | WIDTH | Two's-complement dividend, sampled with start |
| divisor | input | WIDTH | Two's-complement divisor, sampled with start |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| remainder | output | WIDTH | Signed remainder, held until the next accepted start |
| quotient | output | WIDTH | Zero-truncated signed quotient, held with the remainder |

## Verification
The hardest situation to reach is the overflow pair, where exactly one of 2^(2·WIDTH) operand combinations bypasses the loop. The same difficulty applies to the sign corrections at the magnitude extremes, where the most negative value has no positive counterpart. A second instance built with WIDTH=6 takes every one of its 4096 operand pairs. That sweep covers the overflow pair, every zero divisor, every sign combination and both extremes, each checked for value and for latency. The 32-bit instance receives the same corners as directed pairs. It also receives starts during busy, rejected and accepted instruction words, and a reset in the middle of an operation.

// File: rtl/srem_pkg.sv
package srem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_ITER  = 3'd2,
        ST_FIXUP = 3'd3,
        ST_DONE  = 3'd4
    } srem_state_t;

    localparam logic [6:0] OPC_REG_ARITH = 7'b0110011;
    localparam logic [2:0] F3_SIGNED_REM = 3'b110;
    localparam logic [6:0] F7_MULDIV     = 7'b0000001;

    typedef struct packed {
        logic [6:0] funct7;
        logic [4:0] src_b;
        logic [4:0] src_a;
        logic [2:0] funct3;
        logic [4:0] dest;
        logic [6:0] opcode;
    } rtype_word_t;

endpackage

// File: rtl/srem_decode.sv
module srem_decode
    import srem_pkg::*;
(
    input  logic [31:0] instr,
    output logic        is_srem
);

    rtype_word_t fields;
    logic        unused_reg_fields;

    assign fields = rtype_word_t'(instr);

    // Register selectors play no part in the match.
    assign unused_reg_fields = ^{fields.src_b, fields.src_a, fields.dest};

    always_comb begin
        is_srem = (fields.opcode == OPC_REG_ARITH) &&
                  (fields.funct3 == F3_SIGNED_REM) &&
                  (fields.funct7 == F7_MULDIV);
    end

endmodule

// File: rtl/srem_classify.sv
module srem_classify #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             div_zero,
    output logic             overflow,
    output logic             neg_a,
    output logic             neg_b,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b
);

    localparam logic [WIDTH-1:0] MOST_NEG  = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] MINUS_ONE = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO      = '0;

    always_comb begin
        neg_a    = op_a[WIDTH-1];
        neg_b    = op_b[WIDTH-1];
        div_zero = (op_b == ZERO);
        overflow = (op_a == MOST_NEG) && (op_b == MINUS_ONE);
        // Magnitudes as unsigned; the most negative value maps to 2^(WIDTH-1).
        mag_a    = neg_a ? (ZERO - op_a) : op_a;
        mag_b    = neg_b ? (ZERO - op_b) : op_b;
    end

endmodule

// File: rtl/srem_iter.sv
module srem_iter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             step,
    input  logic [WIDTH-1:0] dvd_mag,
    input  logic [WIDTH-1:0] dvs_mag,
    output logic [WIDTH-1:0] part_rem,
    output logic [WIDTH-1:0] part_quo
);

    logic [WIDTH:0]   rem_acc_q;
    logic [WIDTH-1:0] quo_shift_q;
    logic [WIDTH:0]   shifted;
    logic [WIDTH:0]   trial;
    logic             fits;

    always_comb begin
        shifted = {rem_acc_q[WIDTH-1:0], quo_shift_q[WIDTH-1]};
        trial   = shifted - {1'b0, dvs_mag};
        fits    = ~trial[WIDTH];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_acc_q   <= '0;
            quo_shift_q <= '0;
        end else if (init) begin
            rem_acc_q   <= '0;
            quo_shift_q <= dvd_mag;
        end else if (step) begin
            rem_acc_q   <= fits ? trial : shifted;
            quo_shift_q <= {quo_shift_q[WIDTH-2:0], fits};
        end
    end

    assign part_rem = rem_acc_q[WIDTH-1:0];
    assign part_quo = quo_shift_q;

    // Restoring invariant: the partial remainder stays below the divisor magnitude.
    AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        (step || init) |=> (rem_acc_q < {1'b0, dvs_mag}) || (dvs_mag == '0)); // R1

endmodule

// File: rtl/srem_ctrl.sv
module srem_ctrl
    import srem_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_ok,
    input  logic        special,
    output srem_state_t state,
    output logic        busy,
    output logic        done,
    output logic        load_ops,
    output logic        init_iter,
    output logic        step,
    output logic        spec_en,
    output logic        fix_en
);

    localparam int              CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0]   LAST = CW'(WIDTH - 1);

    srem_state_t state_q;
    srem_state_t state_d;
    logic [CW-1:0] cnt_q;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Step counter for the iterative phase.
    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (state_q == ST_SETUP) cnt_q <= '0;
        else if (state_q == ST_ITER)  cnt_q <= cnt_q + CW'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_SETUP;
            ST_SETUP: state_d = special ? ST_DONE : ST_ITER;
            ST_ITER:  if (cnt_q == LAST) state_d = ST_FIXUP;
            ST_FIXUP: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        load_ops  = 1'b0;
        init_iter = 1'b0;
        step      = 1'b0;
        spec_en   = 1'b0;
        fix_en    = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_ops = start_ok;
            ST_SETUP: begin
                busy      = 1'b1;
                init_iter = ~special;
                spec_en   = special;
            end
            ST_ITER:  begin
                busy = 1'b1;
                step = 1'b1;
            end
            ST_FIXUP: begin
                busy   = 1'b1;
                fix_en = 1'b1;
            end
            ST_DONE:  begin
                busy = 1'b1;
                done = 1'b1;
            end
            default:  ;
        endcase
    end

    assign state = state_q;

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_SETUP)); // R6
    AST_SPECIAL_FAST: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETUP && special) |=> (state_q == ST_DONE)); // R4
    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ITER) |-> (cnt_q <= LAST)); // R4
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE)); // R9

endmodule

// File: rtl/srem_unit.sv
module srem_unit
    import srem_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             check_instr,
    input  logic [31:0]      instr,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] remainder,
    output logic [WIDTH-1:0] quotient
);

    localparam logic [WIDTH-1:0] ZERO = '0;

    srem_state_t      state;
    logic             is_srem;
    logic             start_ok;
    logic             load_ops, init_iter, step, spec_en, fix_en;
    logic [WIDTH-1:0] op_a_q, op_b_q;
    logic             div_zero, overflow, neg_a, neg_b;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic [WIDTH-1:0] part_rem, part_quo;
    logic [WIDTH-1:0] rem_q, quo_q;

    srem_decode u_decode (
        .instr   (instr),
        .is_srem (is_srem)
    );

    assign start_ok = start && (!check_instr || is_srem);

    srem_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_ok  (start_ok),
        .special   (div_zero || overflow),
        .state     (state),
        .busy      (busy),
        .done      (done),
        .load_ops  (load_ops),
        .init_iter (init_iter),
        .step      (step),
        .spec_en   (spec_en),
        .fix_en    (fix_en)
    );

    // Operand capture; held for the whole operation.
    always_ff @(posedge clk) begin
        if (rst) begin
            op_a_q <= '0;
            op_b_q <= '0;
        end else if (load_ops) begin
            op_a_q <= dividend;
            op_b_q <= divisor;
        end
    end

    srem_classify #(.WIDTH(WIDTH)) u_classify (
        .op_a     (op_a_q),
        .op_b     (op_b_q),
        .div_zero (div_zero),
        .overflow (overflow),
        .neg_a    (neg_a),
        .neg_b    (neg_b),
        .mag_a    (mag_a),
        .mag_b    (mag_b)
    );

    srem_iter #(.WIDTH(WIDTH)) u_iter (
        .clk      (clk),
        .rst      (rst),
        .init     (init_iter),
        .step     (step),
        .dvd_mag  (mag_a),
        .dvs_mag  (mag_b),
        .part_rem (part_rem),
        .part_quo (part_quo)
    );

    // Result registers: written by the special path or the sign fixup only.
    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
        end else if (spec_en) begin
            if (div_zero) begin
                rem_q <= op_a_q;
                quo_q <= {WIDTH{1'b1}};
            end else begin
                rem_q <= '0;
                quo_q <= op_a_q;
            end
        end else if (fix_en) begin
            rem_q <= neg_a ? (ZERO - part_rem) : part_rem;
            quo_q <= (neg_a ^ neg_b) ? (ZERO - part_quo) : part_quo;
        end
    end

    assign remainder = rem_q;
    assign quotient  = quo_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> ($stable(remainder) && $stable(quotient))); // R7
    AST_ZERO_DIV_ECHO: assert property (@(posedge clk) disable iff (rst)
        (done && div_zero) |-> (remainder == op_a_q)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (done && overflow) |-> (remainder == ZERO)); // R3
    AST_SIGN_FOLLOWS_DIVIDEND: assert property (@(posedge clk) disable iff (rst)
        (done && remainder != ZERO) |-> (remainder[WIDTH-1] == op_a_q[WIDTH-1])); // R1
    AST_DECODE_GATE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && check_instr && !is_srem) |=> (state == ST_IDLE)); // R8

endmodule

// File: tb/srem_unit_bench.sv
module srem_unit_bench;

    localparam int SW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // 32-bit instance
    logic        st32 = 1'b0, chk32 = 1'b0;
    logic [31:0] ins32 = '0, a32 = '0, b32 = '0;
    logic        busy32, done32;
    logic [31:0] rem32, quo32;

    srem_unit u_srem_unit (
        .clk(clk), .rst(rst), .start(st32), .check_instr(chk32), .instr(ins32),
        .dividend(a32), .divisor(b32), .busy(busy32), .done(done32),
        .remainder(rem32), .quotient(quo32)
    );

    // Small instance for the exhaustive sweep
    logic          sts = 1'b0;
    logic [SW-1:0] as_ = '0, bs = '0;
    logic          busys, dones;
    logic [SW-1:0] rems, quos;

    srem_unit #(.WIDTH(SW)) u_srem_unit_small (
        .clk(clk), .rst(rst), .start(sts), .check_instr(1'b0), .instr(32'h0),
        .dividend(as_), .divisor(bs), .busy(busys), .done(dones),
        .remainder(rems), .quotient(quos)
    );

    int total = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic longint ref_rem(input longint a, input longint b, input int w);
        longint mn = -(longint'(1) <<< (w - 1));
        if (b == 0) return a;
        if (a == mn && b == -1) return 0;
        return a % b;
    endfunction

    function automatic longint ref_quo(input longint a, input longint b, input int w);
        longint mn = -(longint'(1) <<< (w - 1));
        if (b == 0) return -1;
        if (a == mn && b == -1) return a;
        return a / b;
    endfunction

    function automatic longint mask(input longint v, input int w);
        return v & ((longint'(1) <<< w) - 1);
    endfunction

    task automatic op32(input logic [31:0] a, input logic [31:0] b, input logic chk,
                        input logic [31:0] ins, output logic [31:0] r,
                        output logic [31:0] q, output int lat);
        @(negedge clk);
        a32 = a; b32 = b; chk32 = chk; ins32 = ins; st32 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        st32 = 1'b0;
        lat = 1;
        while (!done32 && lat < 80) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        r = rem32; q = quo32;
    endtask

    task automatic opsmall(input logic [SW-1:0] a, input logic [SW-1:0] b,
                           output logic [SW-1:0] r, output logic [SW-1:0] q,
                           output int lat);
        @(negedge clk);
        as_ = a; bs = b; sts = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sts = 1'b0;
        lat = 1;
        while (!dones && lat < 40) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        r = rems; q = quos;
    endtask

    // Full check of one operation result against the reference rules.
    task automatic judge(input longint sa, input longint sb, input int w,
                         input longint r, input longint q, input int lat);
        longint er = ref_rem(sa, sb, w);
        longint eq = ref_quo(sa, sb, w);
        longint mn = -(longint'(1) <<< (w - 1));
        bit     spec = (sb == 0) || (sa == mn && sb == -1);
        string  rq = (sb == 0) ? "R2" : (spec ? "R3" : "R1");
        check(mask(r, w) == mask(er, w), rq, "remainder", mask(r, w), mask(er, w));
        check(mask(q, w) == mask(eq, w), spec ? rq : "R10", "quotient", mask(q, w), mask(eq, w));
        check(lat == (spec ? 2 : w + 3), "R4", "latency", lat, spec ? 2 : w + 3);
        if (!spec) begin
            // R1: sign of a nonzero remainder follows the dividend
            if (mask(r, w) != 0)
                check(((r >>> (w - 1)) & 1) == ((sa < 0) ? 1 : 0), "R1", "sign", r, sa);
            // R10: divisor*quotient + remainder == dividend (mod 2^w)
            check(mask(sb * q + r, w) == mask(sa, w), "R10", "identity",
                  mask(sb * q + r, w), mask(sa, w));
        end
    endtask

    task automatic run32(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r, q;
        int lat;
        op32(a, b, 1'b0, 32'h0, r, q, lat);
        judge(longint'($signed(a)), longint'($signed(b)), 32,
              longint'($signed(r)), longint'($signed(q)), lat);
    endtask

    // Watchdog
    initial begin
        repeat (180000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    localparam logic [31:0] GOOD_INS = 32'b0000001_00101_00110_110_00111_0110011;

    initial begin
        logic [31:0] r, q, held_r, held_q;
        int lat;
        bit stayed;

        repeat (3) @(negedge clk);
        check(!busy32 && !done32, "R9", "reset busy/done", {busy32, done32}, 0);
        rst = 1'b0;

        // Directed 32-bit corners
        run32(32'd7, 32'd3);
        run32(-32'sd7, 32'd3);
        run32(32'd7, -32'sd3);
        run32(-32'sd7, -32'sd3);
        run32(32'd0, 32'd5);
        run32(32'd0, -32'sd5);
        run32(32'd5, 32'd0);
        run32(-32'sd5, 32'd0);
        run32(32'h8000_0000, 32'd0);
        run32(32'h8000_0000, 32'hFFFF_FFFF);
        run32(32'h8000_0000, 32'd1);
        run32(32'h8000_0000, 32'd7);
        run32(32'h7FFF_FFFF, 32'h8000_0000);
        run32(32'h8000_0000, 32'h8000_0000);
        run32(32'hFFFF_FFFF, 32'h7FFF_FFFF);
        run32(32'd123456789, -32'sd1000);
        run32(-32'sd98765432, 32'd77);
        run32(32'd6, 32'd3);

        // R5, R6: start during busy is ignored; busy stays high
        @(negedge clk);
        a32 = -32'sd1001; b32 = 32'd10; chk32 = 1'b0; st32 = 1'b1;
        @(posedge clk); @(negedge clk);
        st32 = 1'b0;
        repeat (5) begin @(posedge clk); @(negedge clk); end
        check(busy32, "R5", "busy mid-operation", busy32, 1);
        a32 = 32'd55; b32 = 32'd0; st32 = 1'b1;
        @(posedge clk); @(negedge clk);
        st32 = 1'b0;
        lat = 0;
        while (!done32 && lat < 80) begin @(posedge clk); lat++; @(negedge clk); end
        check(rem32 == -32'sd1, "R6", "remainder after busy start", rem32, -32'sd1);
        check(quo32 == -32'sd100, "R6", "quotient after busy start", quo32, -32'sd100);
        held_r = rem32; held_q = quo32;

        // R5, R7: one-cycle done, outputs held while inputs move
        @(posedge clk); @(negedge clk);
        check(!done32 && !busy32, "R5", "done single cycle", {done32, busy32}, 0);
        for (int k = 0; k < 6; k++) begin
            a32 = 32'(k * 9 + 1); b32 = 32'(k + 2);
            @(posedge clk); @(negedge clk);
        end
        check(rem32 == held_r && quo32 == held_q, "R7", "held outputs", rem32, held_r);
        check(!busy32, "R6", "no launch without start", busy32, 0);

        // R8: mismatching instruction word rejected (funct3 altered)
        @(negedge clk);
        a32 = 32'd17; b32 = 32'd5; chk32 = 1'b1;
        ins32 = GOOD_INS ^ 32'h0000_2000; st32 = 1'b1;
        @(posedge clk); @(negedge clk);
        st32 = 1'b0;
        stayed = 1'b1;
        for (int k = 0; k < 5; k++) begin
            if (busy32 || done32) stayed = 1'b0;
            @(posedge clk); @(negedge clk);
        end
        check(stayed, "R8", "bad funct3 left idle", stayed, 1);
        check(rem32 == held_r, "R8", "outputs untouched", rem32, held_r);

        // R8: wrong funct7 and wrong opcode rejected too
        ins32 = GOOD_INS ^ 32'h0200_0000; st32 = 1'b1;
        @(posedge clk); @(negedge clk);
        st32 = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!busy32, "R8", "bad funct7 left idle", busy32, 0);
        ins32 = GOOD_INS ^ 32'h0000_0004; st32 = 1'b1;
        @(posedge clk); @(negedge clk);
        st32 = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!busy32, "R8", "bad opcode left idle", busy32, 0);

        // R8: matching word with arbitrary register fields accepted
        op32(32'd17, 32'd5, 1'b1, GOOD_INS | 32'h01FF_8F80, r, q, lat);
        check(r == 32'd2 && lat == 35, "R8", "good word accepted", r, 2);
        // R8: with check off, any word is ignored
        op32(-32'sd17, 32'd5, 1'b0, 32'hDEAD_BEEF, r, q, lat);
        check(r == -32'sd2, "R8", "check off ignores word", r, -32'sd2);

        // R9: reset in the middle of an operation
        @(negedge clk);
        a32 = 32'd1000; b32 = 32'd7; chk32 = 1'b0; st32 = 1'b1;
        @(posedge clk); @(negedge clk);
        st32 = 1'b0;
        repeat (4) begin @(posedge clk); @(negedge clk); end
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!busy32 && !done32, "R9", "mid-op reset", {busy32, done32}, 0);
        rst = 1'b0;
        run32(32'd1000, 32'd7);

        // Exhaustive sweep of the small instance
        for (int i = 0; i < (1 << SW); i++) begin
            for (int j = 0; j < (1 << SW); j++) begin
                logic [SW-1:0] rs, qs;
                int ls;
                opsmall(SW'(i), SW'(j), rs, qs, ls);
                judge(longint'($signed(SW'(i))), longint'($signed(SW'(j))), SW,
                      longint'($signed(rs)), longint'($signed(qs)), ls);
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule